// File: doc/BRIEF.md
# Sub-word Register Access Adapter

This block connects a little-endian I/O port that issues 1-, 2- or 4-byte accesses to a set of register targets that can only take aligned 32-bit reads and writes. It splits a 128-byte window by offset. The lowest 64 bytes address the SCSI core registers. The next 32 bytes address the DMA channel registers. The bus-control word lives inside the adapter itself.

A read fetches one 32-bit word from its target. The requested byte lanes are moved down to bit 0 and the lanes above the access size are cleared. A write that is narrower than a word, or whose address is not aligned, becomes a read-modify-write. The adapter first reads the current word. It then overlays the new bytes using a fixed lane-shift rule, and finally writes the full word to the aligned offset. Writes to unmapped offsets are dropped and reported on an error pulse.

The port takes one request at a time. A request is accepted when `req_valid` is high and the adapter is idle. Completion is marked by a one-cycle `rsp_ready` pulse.

Top module: `subword_adapter`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `rsp_ready`, `rsp_err` and all four target strobes are low, and `busctl_q` is zero.
- R2: Offsets 0x00 to 0x3F select the core target, with `core_idx` = offset>>2. A read pulses `core_rd` in the cycle after acceptance.
- R3: Offsets 0x40 to 0x5F select the DMA target, with `dma_idx` = (offset-0x40)>>2. A read pulses `dma_rd` in the cycle after acceptance.
- R4: A read returns the bus-control word only at the exact offset 0x70. Reads at 0x60 to 0x6F, 0x71 to 0x7F return 0 and pulse no strobe.
- R5: A write of size 4 to an aligned offset pulses the target's write strobe in the cycle after acceptance, with `be_wdata` equal to `req_wdata`. `rsp_ready` is high for one cycle in the cycle after that.
- R6: For a write with size below 4 or a nonzero address[1:0], the sequence is as follows.
  - The target read strobe pulses in cycle 1 and the write strobe pulses in cycle 2, both at the aligned offset. `rsp_ready` is high in cycle 3.
  - The word written takes byte k of `req_wdata` (k < size) into lane ((4-address[1:0]) mod 4)+k. Lanes at 4 or above are discarded.
  - All other lanes keep their current value.
  - Bytes of `req_wdata` at or above `size` are ignored.
- R7: For a narrow write, the current word is `busctl_q` at offsets 0x60 to 0x73 and zero at 0x74 and above. A write whose aligned offset is 0x70 loads `busctl_q`, so a narrow write to 0x71 to 0x73 also updates it.
- R8: A write whose aligned offset lies in 0x60 to 0x6F or 0x74 to 0x7F changes no target. It pulses no write strobe and raises `rsp_err` together with `rsp_ready`.
- R9: Read data is the target word shifted right by 8*address[1:0], keeping the low 8*size bits and clearing the rest. The response arrives 2 cycles after acceptance.
- R10: `req_size` codes 0 and 5 to 7 behave as size 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset in the window |
| req_size | input | 3 | Access size in bytes (1..4) |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready on reads |
| rsp_err | output | 1 | Unmapped write, pulses with rsp_ready |
| core_rd | output | 1 | Core target read strobe |
| core_wr | output | 1 | Core target write strobe |
| core_idx | output | 4 | Core register index |
| core_rdata | input | 32 | Core register word for core_idx, combinational |
| dma_rd | output | 1 | DMA target read strobe |
| dma_wr | output | 1 | DMA target write strobe |
| dma_idx | output | 3 | DMA register index |
| dma_rdata | input | 32 | DMA register word for dma_idx, combinational |
| be_wdata | output | 32 | Full word written with core_wr or dma_wr |
| busctl_q | output | 32 | Bus-control register contents |

## Verification
The bench goes after the lane-shift merge at every address offset and size:
- A design that shifted narrow write data by 8*address[1:0] would overwrite the wrong byte lane.
- One that did not clip at lane 4 would corrupt the low lanes.
- One that failed to mask the high bytes of `req_wdata` would leak garbage into neighbouring lanes.

It also probes the asymmetry between read and write decode around 0x70. Reads at 0x71 must return zero, while narrow writes there must update the bus-control word through its merge. Writes at 0x60 and 0x74 and above must be dropped with an error, without disturbing `busctl_q`.

Finally, it checks each strobe and the response in its exact cycle. This catches a merge that writes before reading, or a response that is one cycle early or late.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {TGT_NONE, TGT_CORE, TGT_DMA, TGT_CTL} tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DONE} st_e;

  // bytes -> low-lane mask; size is already normalised to 1..4
  function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] size);
    case (size)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd3:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // left shift used by the merge: ((4 - lo) & 3) * 8
  function automatic logic [4:0] merge_shift(input logic [1:0] lo);
    logic [1:0] neg;
    neg = 2'd0 - lo;
    return {neg, 3'b000};
  endfunction

  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] wd,
                                                   input logic [DATA_W-1:0] cur,
                                                   input logic [2:0]        size,
                                                   input logic [1:0]        lo);
    logic [DATA_W-1:0] m;
    logic [4:0]        sh;
    sh = merge_shift(lo);
    m  = lane_mask(size) << sh;
    return ((wd << sh) & m) | (cur & ~m);
  endfunction

  function automatic logic [DATA_W-1:0] extract_word(input logic [DATA_W-1:0] w,
                                                     input logic [2:0]        size,
                                                     input logic [1:0]        lo);
    return (w >> {lo, 3'b000}) & lane_mask(size);
  endfunction

endpackage

// File: rtl/sa_decode.sv
module sa_decode
  import sa_pkg::*;
#(
  parameter int unsigned AW         = 7,
  parameter int unsigned CORE_END   = 64,
  parameter int unsigned DMA_END    = 96,
  parameter int unsigned CTL_OFS    = 112,
  parameter int unsigned CORE_IDX_W = 4,
  parameter int unsigned DMA_IDX_W  = 3
) (
  input  logic [AW-1:0]         addr,
  output tgt_e                  rd_tgt,
  output tgt_e                  wr_tgt,
  output logic                  merge_ctl,
  output logic [CORE_IDX_W-1:0] core_idx,
  output logic [DMA_IDX_W-1:0]  dma_idx
);
  localparam logic [AW-1:0] CE = AW'(CORE_END);
  localparam logic [AW-1:0] DE = AW'(DMA_END);
  localparam logic [AW-1:0] CO = AW'(CTL_OFS);
  localparam logic [AW-1:0] CM = AW'(CTL_OFS + 4);

  logic [AW-1:0] aligned;
  assign aligned = {addr[AW-1:2], 2'b00};

  // read side: exact match on the control offset
  always_comb begin
    if (addr < CE)       rd_tgt = TGT_CORE;
    else if (addr < DE)  rd_tgt = TGT_DMA;
    else if (addr == CO) rd_tgt = TGT_CTL;
    else                 rd_tgt = TGT_NONE;
  end

  // write side: decoded on the widened, aligned offset
  always_comb begin
    if (aligned < CE)       wr_tgt = TGT_CORE;
    else if (aligned < DE)  wr_tgt = TGT_DMA;
    else if (aligned == CO) wr_tgt = TGT_CTL;
    else                    wr_tgt = TGT_NONE;
  end

  assign merge_ctl = (addr >= DE) && (addr < CM);
  assign core_idx  = CORE_IDX_W'(addr >> 2);
  assign dma_idx   = DMA_IDX_W'((addr - CE) >> 2);
endmodule

// File: rtl/sa_lane_unit.sv
module sa_lane_unit
  import sa_pkg::*;
(
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        size,
  input  logic [1:0]        lo,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] extracted
);
  assign merged    = merge_word(wdata, cur, size, lo);
  assign extracted = extract_word(cur, size, lo);
endmodule

// File: rtl/sa_seq.sv
module sa_seq
  import sa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_narrow,
  output st_e  st,
  output logic acc,
  output logic write_q
);
  st_e st_n;

  assign acc = (st == ST_IDLE) && req_valid;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (req_valid) st_n = (!req_write || req_narrow) ? ST_RD : ST_WR;
      ST_RD:   st_n = write_q ? ST_WR : ST_DONE;
      ST_WR:   st_n = ST_DONE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      write_q <= 1'b0;
    end else begin
      st <= st_n;
      if (acc) write_q <= req_write;
    end
  end
endmodule

// File: rtl/subword_adapter.sv
module subword_adapter
  import sa_pkg::*;
#(
  parameter  int unsigned AW         = 7,
  parameter  int unsigned CORE_END   = 64,
  parameter  int unsigned DMA_END    = 96,
  parameter  int unsigned CTL_OFS    = 112,
  localparam int unsigned CORE_IDX_W = $clog2(CORE_END / 4),
  localparam int unsigned DMA_IDX_W  = $clog2((DMA_END - CORE_END) / 4)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [2:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  output logic                  core_rd,
  output logic                  core_wr,
  output logic [CORE_IDX_W-1:0] core_idx,
  input  logic [31:0]           core_rdata,
  output logic                  dma_rd,
  output logic                  dma_wr,
  output logic [DMA_IDX_W-1:0]  dma_idx,
  input  logic [31:0]           dma_rdata,
  output logic [31:0]           be_wdata,
  output logic [31:0]           busctl_q
);
  st_e            st;
  logic           acc, write_q;
  logic [AW-1:0]  addr_q;
  logic [2:0]     size_q, eff_size;
  logic           narrow_in, narrow_q;
  logic [31:0]    wdata_q, rdata_q, cur_word, merged, extracted;
  tgt_e           rd_tgt, wr_tgt;
  logic           merge_ctl, use_ctl, ctl_we;

  // R10: out-of-range size codes act as a full word
  assign eff_size  = (req_size inside {3'd1, 3'd2, 3'd3}) ? req_size : 3'd4;
  assign narrow_in = (eff_size != 3'd4) || (req_addr[1:0] != 2'b00);

  sa_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_narrow (narrow_in),
    .st         (st),
    .acc        (acc),
    .write_q    (write_q)
  );

  sa_decode #(
    .AW         (AW),
    .CORE_END   (CORE_END),
    .DMA_END    (DMA_END),
    .CTL_OFS    (CTL_OFS),
    .CORE_IDX_W (CORE_IDX_W),
    .DMA_IDX_W  (DMA_IDX_W)
  ) u_dec (
    .addr      (addr_q),
    .rd_tgt    (rd_tgt),
    .wr_tgt    (wr_tgt),
    .merge_ctl (merge_ctl),
    .core_idx  (core_idx),
    .dma_idx   (dma_idx)
  );

  // current-word source for a read or a merge
  assign use_ctl = write_q ? merge_ctl : (rd_tgt == TGT_CTL);

  always_comb begin
    case (rd_tgt)
      TGT_CORE: cur_word = core_rdata;
      TGT_DMA:  cur_word = dma_rdata;
      default:  cur_word = use_ctl ? busctl_q : '0;
    endcase
  end

  sa_lane_unit u_lane (
    .cur       (cur_word),
    .wdata     (wdata_q),
    .size      (size_q),
    .lo        (addr_q[1:0]),
    .merged    (merged),
    .extracted (extracted)
  );

  assign core_rd   = (st == ST_RD) && (rd_tgt == TGT_CORE);
  assign dma_rd    = (st == ST_RD) && (rd_tgt == TGT_DMA);
  assign core_wr   = (st == ST_WR) && (wr_tgt == TGT_CORE);
  assign dma_wr    = (st == ST_WR) && (wr_tgt == TGT_DMA);
  assign ctl_we    = (st == ST_WR) && (wr_tgt == TGT_CTL);
  assign rsp_ready = (st == ST_DONE);
  assign rsp_err   = (st == ST_DONE) && write_q && (wr_tgt == TGT_NONE);
  assign rsp_rdata = rdata_q;
  assign be_wdata  = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      size_q   <= 3'd4;
      narrow_q <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      busctl_q <= '0;
    end else begin
      if (acc) begin
        addr_q   <= req_addr;
        size_q   <= eff_size;
        narrow_q <= req_write && narrow_in;
        wdata_q  <= req_wdata;
      end
      if (st == ST_RD) begin
        if (write_q) wdata_q <= merged;
        else         rdata_q <= extracted;
      end
      if (ctl_we) busctl_q <= wdata_q;
    end
  end
endmodule

// File: rtl/sa_checker.sv
module sa_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        core_rd,
  input logic        core_wr,
  input logic        dma_rd,
  input logic        dma_wr,
  input logic        ctl_we,
  input logic        narrow_q,
  input logic        rsp_ready,
  input logic        rsp_err,
  input logic        acc,
  input logic        req_write,
  input logic [31:0] busctl_q
);
  // R2 R3: one target strobe at a time
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_rd, core_wr, dma_rd, dma_wr}));

  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  p_wr_then_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr || dma_wr || ctl_we) |=> rsp_ready);

  p_core_merge_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && narrow_q) |-> $past(core_rd));

  p_dma_merge_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && narrow_q) |-> $past(dma_rd));

  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(busctl_q));

  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_ready && !$past(core_wr || dma_wr || ctl_we)));

  p_read_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> !(core_wr || dma_wr || ctl_we));
endmodule

bind subword_adapter sa_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .core_rd   (core_rd),
  .core_wr   (core_wr),
  .dma_rd    (dma_rd),
  .dma_wr    (dma_wr),
  .ctl_we    (ctl_we),
  .narrow_q  (narrow_q),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .acc       (acc),
  .req_write (req_write),
  .busctl_q  (busctl_q)
);

// File: tb/test_subword_adapter.sv
`timescale 1ns/1ps
module test_subword_adapter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [6:0]  req_addr = 0;
  logic [2:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_ready, rsp_err, core_rd, core_wr, dma_rd, dma_wr;
  logic [31:0] rsp_rdata, core_rdata, dma_rdata, be_wdata, busctl_q;
  logic [3:0]  core_idx;
  logic [2:0]  dma_idx;

  int n_tests = 0, n_fail = 0;
  logic [31:0] core_mem [16];
  logic [31:0] dma_mem [8];
  logic [31:0] mctl = 0;

  always #10 clk = ~clk;

  subword_adapter i_subword_adapter (.*);

  // back-end register files
  assign core_rdata = core_mem[core_idx];
  assign dma_rdata  = dma_mem[dma_idx];
  always @(posedge clk) begin
    if (core_wr) core_mem[core_idx] <= be_wdata;
    if (dma_wr)  dma_mem[dma_idx]   <= be_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] sig_vec();
    return {core_rd, core_wr, dma_rd, dma_wr, rsp_ready, rsp_err};
  endfunction

  // reference current word, byte-lane merge and byte-lane extract
  function automatic logic [31:0] ref_word(input int a, input bit for_merge);
    if (a < 64)                  return core_mem[a / 4];
    if (a < 96)                  return dma_mem[(a - 64) / 4];
    if (for_merge && a < 116)    return mctl;
    if (!for_merge && a == 112)  return mctl;
    return 32'h0;
  endfunction

  function automatic logic [31:0] ref_merge(input logic [31:0] cur, input logic [31:0] wd,
                                            input int lo, input int es);
    logic [31:0] r;
    int s;
    r = cur;
    s = (4 - lo) % 4;
    for (int k = 0; k < es; k++)
      if (s + k < 4) r[(s + k) * 8 +: 8] = wd[k * 8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] ref_extract(input logic [31:0] w, input int lo, input int es);
    logic [31:0] r;
    r = 0;
    for (int j = 0; j < es; j++)
      if (lo + j < 4) r[j * 8 +: 8] = w[(lo + j) * 8 +: 8];
    return r;
  endfunction

  // one access, checked cycle by cycle; called and returns at a falling edge
  task automatic access(input bit wr, input int addr, input int sz,
                        input logic [31:0] wd, input string req);
    int es, rk, wk, aa;
    bit nar;
    logic [31:0] cur, mw;
    logic [5:0] ev;
    es  = (sz >= 1 && sz <= 3) ? sz : 4;
    nar = wr && (es < 4 || (addr % 4) != 0);
    aa  = addr & ~3;
    rk  = (addr < 64) ? 1 : (addr < 96) ? 2 : 0;
    wk  = (aa < 64) ? 1 : (aa < 96) ? 2 : (aa == 112) ? 3 : 0;
    cur = ref_word(addr, wr);
    mw  = nar ? ref_merge(cur, wd, addr % 4, es) : wd;
    req_valid = 1; req_write = wr; req_addr = 7'(addr);
    req_size = 3'(sz); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (!wr || nar) begin
      ev = {rk == 1, 1'b0, rk == 2, 1'b0, 1'b0, 1'b0};
      chk(sig_vec() == ev, req, "read-phase strobes", 32'(sig_vec()), 32'(ev));
      if (rk == 1) chk(core_idx == 4'(addr / 4), req, "core_idx", 32'(core_idx), addr / 4);
      if (rk == 2) chk(dma_idx == 3'((addr - 64) / 4), req, "dma_idx", 32'(dma_idx), (addr - 64) / 4);
      @(negedge clk);
    end
    if (wr) begin
      ev = {1'b0, wk == 1, 1'b0, wk == 2, 1'b0, 1'b0};
      chk(sig_vec() == ev, req, "write-phase strobes", 32'(sig_vec()), 32'(ev));
      if (wk == 1 || wk == 2) chk(be_wdata == mw, req, "be_wdata", be_wdata, mw);
      if (wk == 3) mctl = mw;
      @(negedge clk);
    end
    ev = {4'b0, 1'b1, wr && wk == 0};
    chk(sig_vec() == ev, req, "response strobes", 32'(sig_vec()), 32'(ev));
    if (!wr) chk(rsp_rdata == ref_extract(cur, addr % 4, es), req, "rdata",
                 rsp_rdata, ref_extract(cur, addr % 4, es));
    @(negedge clk);
    chk(sig_vec() == 6'b0, req, "idle after response", 32'(sig_vec()), 0);
    chk(busctl_q == mctl, req, "busctl_q", busctl_q, mctl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) core_mem[i] = 32'h1000_0000 + i * 32'h0101_0101;
    for (int i = 0; i < 8; i++)  dma_mem[i]  = 32'h8000_0000 + i * 32'h0011_0011;
    repeat (3) @(negedge clk);
    chk(sig_vec() == 6'b0, "R1", "outputs in reset", 32'(sig_vec()), 0);
    rst_n = 1;
    @(negedge clk);
    chk(sig_vec() == 6'b0, "R1", "outputs after reset", 32'(sig_vec()), 0);
    chk(busctl_q == 0, "R1", "busctl_q after reset", busctl_q, 0);

    // full aligned writes and reads
    access(1, 8'h08, 4, 32'hA1B2C3D4, "R5 R2");
    access(0, 8'h08, 4, 0, "R2 R9");
    access(1, 8'h44, 4, 32'h11223344, "R5 R3");
    access(0, 8'h44, 4, 0, "R3 R9");
    access(0, 8'h5C, 4, 0, "R3");

    // narrow and misaligned writes at every lane
    access(1, 8'h08, 1, 32'hFFFFFF5A, "R6");
    access(1, 8'h09, 1, 32'h000000E7, "R6");
    access(1, 8'h0A, 2, 32'hDEAD9876, "R6");
    access(1, 8'h0B, 1, 32'h00000042, "R6");
    access(1, 8'h0D, 4, 32'h99887766, "R6");
    access(1, 8'h0E, 3, 32'h00ABCDEF, "R6");
    access(0, 8'h08, 4, 0, "R6 R9");
    access(0, 8'h0C, 4, 0, "R6 R9");
    access(1, 8'h5E, 2, 32'h0000BEEF, "R6 R3");
    access(0, 8'h5C, 4, 0, "R6 R3");

    // every read lane and size
    access(1, 8'h20, 4, 32'h89ABCDEF, "R5");
    for (int a = 0; a < 4; a++)
      for (int s = 1; s <= 4; s++) access(0, 32 + a, s, 0, "R9");

    // bus-control decode
    access(1, 8'h70, 4, 32'hCAFEF00D, "R7 R5");
    access(0, 8'h70, 4, 0, "R4 R7");
    access(0, 8'h71, 1, 0, "R4");
    access(0, 8'h72, 2, 0, "R4");
    access(1, 8'h71, 1, 32'h00000077, "R7");
    access(1, 8'h73, 2, 32'h00005511, "R7");
    access(0, 8'h70, 4, 0, "R7");

    // unmapped writes and reads
    access(1, 8'h62, 2, 32'h0000FFFF, "R8");
    access(1, 8'h64, 4, 32'h12345678, "R8");
    access(1, 8'h7C, 1, 32'h000000AA, "R8");
    access(1, 8'h75, 4, 32'h0BADF00D, "R8");
    access(0, 8'h60, 4, 0, "R4");
    access(0, 8'h7F, 1, 0, "R4");
    access(0, 8'h70, 4, 0, "R8");

    // size codes outside 1..4
    access(1, 8'h10, 0, 32'h5566AA77, "R10");
    access(0, 8'h10, 7, 0, "R10");
    access(0, 8'h11, 5, 0, "R10");
    access(1, 8'h14, 6, 32'h0F0E0D0C, "R10");
    access(0, 8'h14, 4, 0, "R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule